// File: doc/BRIEF.md
# Bus Access Width Splitter

This block sits between an internal bus that issues 8-, 16-, 32- or 64-bit read and write requests and a narrow external asynchronous memory port whose devices are either 8 or 16 bits wide. It accepts one request at a time. A wide request is cut into a run of device-width beats, and each beat gets its own external address, chip-select line, data slice and byte enables.

A strobe-timing engine downstream runs each beat and signals its end with `ext_ready`. Beats always go out from the lowest external address to the highest. The endianness input changes only which slice of the request word travels with each beat. Read beats are gathered back into one word. Every request, read or write, ends with a single completion pulse.

Each chip select has its own static width bit. The external address counts device words, not bytes: it is the request byte address shifted right by log2 of the device width in bytes.

Top module: `bus_width_splitter`

## Requirements
- R1: The beat count is the request size divided by the device width. A request no wider than the device is one beat, and its data and enables come from the low device-width slice of `req_wdata`/`req_be`. `req_size` encodes 0=8, 1=16, 2=32 and 3=64 bits, and request data sits in the low bits.
- R2: `cs_is_8bit[i]`=1 makes chip select i an 8-bit device, and 0 makes it a 16-bit device. Beats to an 8-bit device drive `ext_wdata[7:0]` and `ext_be[0]`, with `ext_wdata[15:8]` and `ext_be[1]` at zero. `ext_cs` is one-hot, with bit i for chip select i.
- R3: The beats of one request use consecutive ascending external addresses, starting at the lowest. The order is the same for both endianness settings.
- R4: The first beat's address is `req_addr` in bytes divided by the device width in bytes. For example, a 32-bit access at byte 0 of a 16-bit device gives addresses 0 and then 1.
- R5: A lane is a device-width slice of the request word, and lane 0 is the least significant. With `big_endian`=0, beat k carries lane k. With `big_endian`=1, beat k carries lane n-1-k, where n is the beat count.
- R6: Byte enables are split with the same lane as the data. A beat whose enables are all zero is still issued.
- R7: For a read, each returned beat (`ext_rdata`, low byte only for 8-bit devices) is placed in its lane. `rsp_valid` pulses for exactly one cycle, in the cycle after the last beat's handshake, with the full word on `rsp_rdata`. Writes also get exactly one `rsp_valid` pulse.
- R8: A request is accepted on `req_valid && req_ready`. `req_ready` is low from the next cycle until the cycle after the last beat completes. `ext_valid` rises in the cycle after acceptance, and `ext_cs` is zero when `ext_valid` is low.
- R9: While `ext_valid` is high and `ext_ready` is low, the beat's address, data, enables and chip select hold steady.
- R10: After reset, `req_ready`=1 and `ext_valid`, `rsp_valid` and `ext_cs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Static lane order select |
| cs_is_8bit | input | NUM_CS | Per chip select device width, 1 = 8-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | $clog2(NUM_CS) | Target chip select |
| req_addr | input | ADDR_W | Byte address inside the chip select |
| req_size | input | 2 | Access size code |
| req_wdata | input | DATA_W | Write data, low-aligned |
| req_be | input | DATA_W/8 | Write byte enables |
| ext_valid | output | 1 | Beat on the external port |
| ext_ready | input | 1 | Beat finished |
| ext_write | output | 1 | Beat direction |
| ext_cs | output | NUM_CS | One-hot chip select |
| ext_addr | output | ADDR_W | Device-word address |
| ext_wdata | output | 16 | Beat write data |
| ext_be | output | 2 | Beat byte enables |
| ext_rdata | input | 16 | Beat read data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | DATA_W | Assembled read word |

## Verification
Requests of 32 and 64 bits are sent to both 16-bit and 8-bit chip selects under both endianness settings. Identical stimulus under the two settings must produce the same address sequence but mirrored lane contents, which separates address ordering from lane mapping. Single-beat 8- and 16-bit requests, an enable mask that leaves whole beats with zero enables, and stretched beats (ready held off for several cycles) check the beat count, the zero-enable issue rule and the hold rule. Reads against an address-dependent responder show whether each returned beat lands in the right slot.

// File: rtl/bws_pkg.sv
package bws_pkg;
   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2,
      SZ_64 = 2'd3
   } req_size_e;

   localparam int EXT_DW = 16;
endpackage

// File: rtl/bws_beat_plan.sv
module bws_beat_plan #(
   parameter int ADDR_W = 24,
   parameter int IDX_W  = 3
) (
   input  logic [1:0]        size,
   input  logic              dev8,
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  last_idx,
   output logic [ADDR_W-1:0] base
);
   localparam int CW = IDX_W + 1;

   logic [1:0]    dev_log;
   logic [1:0]    beat_log;
   logic [CW-1:0] count;

   always_comb begin
      dev_log  = dev8 ? 2'd0 : 2'd1;
      beat_log = (size > dev_log) ? (size - dev_log) : 2'd0;
      count    = CW'(1) << beat_log;
      last_idx = IDX_W'(count - CW'(1));
      base     = dev8 ? addr : (addr >> 1);
   end
endmodule

// File: rtl/bws_lane_mux.sv
module bws_lane_mux #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] be,
   input  logic [IDX_W-1:0]    lane,
   input  logic                dev8,
   output logic [15:0]         ext_wdata,
   output logic [1:0]          ext_be
);
   localparam int STRB_W = DATA_W / 8;

   logic [IDX_W+4:0] dshift;
   logic [IDX_W:0]   bshift;
   logic [DATA_W-1:0] dsh;
   logic [STRB_W-1:0] bsh;

   always_comb begin
      dshift    = dev8 ? {2'b00, lane, 3'b000} : {1'b0, lane, 4'b0000};
      bshift    = dev8 ? {1'b0, lane} : {lane, 1'b0};
      dsh       = wdata >> dshift;
      bsh       = be >> bshift;
      ext_wdata = dev8 ? {8'h00, dsh[7:0]} : dsh[15:0];
      ext_be    = dev8 ? {1'b0, bsh[0]} : bsh[1:0];
   end
endmodule

// File: rtl/bws_read_pack.sv
module bws_read_pack #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic [IDX_W-1:0]  lane,
   input  logic              dev8,
   input  logic [15:0]       rdata,
   output logic [DATA_W-1:0] word
);
   logic [IDX_W+4:0]  dshift;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] ins;

   always_comb begin
      dshift = dev8 ? {2'b00, lane, 3'b000} : {1'b0, lane, 4'b0000};
      mask   = dev8 ? DATA_W'(8'hFF) : DATA_W'(16'hFFFF);
      ins    = dev8 ? DATA_W'(rdata[7:0]) : DATA_W'(rdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word <= '0;
      else if (clear)   word <= '0;
      else if (capture) word <= (word & ~(mask << dshift)) | (ins << dshift);
   end
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
   parameter int NUM_CS = 4,
   parameter int ADDR_W = 24,
   parameter int DATA_W = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       big_endian,
   input  logic [NUM_CS-1:0]          cs_is_8bit,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_write,
   input  logic [$clog2(NUM_CS)-1:0]  req_cs,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [1:0]                 req_size,
   input  logic [DATA_W-1:0]          req_wdata,
   input  logic [DATA_W/8-1:0]        req_be,
   output logic                       ext_valid,
   input  logic                       ext_ready,
   output logic                       ext_write,
   output logic [NUM_CS-1:0]          ext_cs,
   output logic [ADDR_W-1:0]          ext_addr,
   output logic [15:0]                ext_wdata,
   output logic [1:0]                 ext_be,
   input  logic [15:0]                ext_rdata,
   output logic                       rsp_valid,
   output logic [DATA_W-1:0]          rsp_rdata
);
   import bws_pkg::*;

   localparam int STRB_W    = DATA_W / 8;
   localparam int MAX_BEATS = STRB_W;
   localparam int IDX_W     = $clog2(MAX_BEATS);
   localparam int CS_W      = $clog2(NUM_CS);

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data
         $error("DATA_W must be 32 or 64");
      end
      if (NUM_CS < 2) begin : g_bad_cs
         $error("NUM_CS must be at least 2");
      end
      if (EXT_DW != 16) begin : g_bad_ext
         $error("external bus must be 16 bits");
      end
   endgenerate

   logic              busy;
   logic [IDX_W-1:0]  beat_idx;
   logic [IDX_W-1:0]  last_q;
   logic [ADDR_W-1:0] base_q;
   logic              write_q;
   logic              dev8_q;
   logic [CS_W-1:0]   cs_q;
   logic [DATA_W-1:0] wdata_q;
   logic [STRB_W-1:0] be_q;
   logic              rsp_q;

   logic [IDX_W-1:0]  plan_last;
   logic [ADDR_W-1:0] plan_base;
   logic              req_dev8;
   logic [IDX_W-1:0]  lane;
   logic              accept;
   logic              beat_done;
   logic              last_beat;
   req_size_e         size_e;

   assign size_e    = req_size_e'(req_size);
   assign req_dev8  = cs_is_8bit[req_cs];
   assign accept    = req_valid && !busy;
   assign beat_done = busy && ext_ready;
   assign last_beat = (beat_idx == last_q);
   assign lane      = big_endian ? (last_q - beat_idx) : beat_idx;

   bws_beat_plan #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_plan (
      .size     (size_e),
      .dev8     (req_dev8),
      .addr     (req_addr),
      .last_idx (plan_last),
      .base     (plan_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         beat_idx <= '0;
         last_q   <= '0;
         base_q   <= '0;
         write_q  <= 1'b0;
         dev8_q   <= 1'b0;
         cs_q     <= '0;
         wdata_q  <= '0;
         be_q     <= '0;
         rsp_q    <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            beat_idx <= '0;
            last_q   <= plan_last;
            base_q   <= plan_base;
            write_q  <= req_write;
            dev8_q   <= req_dev8;
            cs_q     <= req_cs;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
         end else if (beat_done) begin
            if (last_beat) begin
               busy  <= 1'b0;
               rsp_q <= 1'b1;
            end else begin
               beat_idx <= beat_idx + 1'b1;
            end
         end
      end
   end

   bws_lane_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lane (
      .wdata     (wdata_q),
      .be        (be_q),
      .lane      (lane),
      .dev8      (dev8_q),
      .ext_wdata (ext_wdata),
      .ext_be    (ext_be)
   );

   bws_read_pack #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .capture (beat_done && !write_q),
      .lane    (lane),
      .dev8    (dev8_q),
      .rdata   (ext_rdata),
      .word    (rsp_rdata)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
         assign ext_cs[gi] = busy && (cs_q == CS_W'(gi));
      end
   endgenerate

   assign req_ready = !busy;
   assign ext_valid = busy;
   assign ext_write = write_q;
   assign ext_addr  = base_q + ADDR_W'(beat_idx);
   assign rsp_valid = rsp_q;
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
   parameter int NUM_CS = 4,
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CS-1:0] cs_is_8bit,
   input logic              req_valid,
   input logic              req_ready,
   input logic              ext_valid,
   input logic              ext_ready,
   input logic [NUM_CS-1:0] ext_cs,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [15:0]       ext_wdata,
   input logic [1:0]        ext_be,
   input logic              rsp_valid
);
   AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ext_valid && ext_ready) && ext_valid) |-> (ext_addr == $past(ext_addr) + 1'b1)); // R3

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr) && $stable(ext_wdata)
                                     && $stable(ext_be) && $stable(ext_cs))); // R9

   AST_NARROW_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && ((ext_cs & cs_is_8bit) != '0)) |-> (ext_wdata[15:8] == 8'h00 && !ext_be[1])); // R2

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> ($countones(ext_cs) == 1)); // R2

   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_valid |-> (ext_cs == '0)); // R8

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> !req_ready); // R8

   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ext_valid && !req_ready)); // R8

   AST_RSP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(ext_valid && ext_ready)); // R7

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7
endmodule

bind bus_width_splitter bws_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_is_8bit (cs_is_8bit),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .ext_valid  (ext_valid),
   .ext_ready  (ext_ready),
   .ext_cs     (ext_cs),
   .ext_addr   (ext_addr),
   .ext_wdata  (ext_wdata),
   .ext_be     (ext_be),
   .rsp_valid  (rsp_valid)
);

// File: tb/bus_width_splitter_tb.sv
module bus_width_splitter_tb;
   localparam int NUM_CS = 4;
   localparam int ADDR_W = 24;
   localparam int DATA_W = 64;

   typedef struct packed {
      logic [1:0]  cs;
      logic [1:0]  size;
      logic [23:0] addr;
      logic        wr;
      logic        bige;
      logic [7:0]  be;
      logic [1:0]  dly;
      logic [3:0]  nb;
      logic [23:0] base;
   } vec_t;

   // chip selects 1 and 3 are 8-bit, 0 and 2 are 16-bit
   localparam vec_t VECS [12] = '{
      '{2'd0, 2'd2, 24'h000000, 1'b0, 1'b0, 8'hFF, 2'd0, 4'd2, 24'h000000},
      '{2'd0, 2'd2, 24'h000000, 1'b0, 1'b1, 8'hFF, 2'd0, 4'd2, 24'h000000},
      '{2'd0, 2'd3, 24'h000008, 1'b1, 1'b0, 8'hFF, 2'd0, 4'd4, 24'h000004},
      '{2'd0, 2'd3, 24'h000008, 1'b1, 1'b1, 8'hFF, 2'd1, 4'd4, 24'h000004},
      '{2'd1, 2'd2, 24'h000004, 1'b1, 1'b0, 8'h0F, 2'd0, 4'd4, 24'h000004},
      '{2'd1, 2'd3, 24'h000010, 1'b0, 1'b1, 8'hFF, 2'd0, 4'd8, 24'h000010},
      '{2'd3, 2'd3, 24'h000018, 1'b0, 1'b0, 8'hFF, 2'd2, 4'd8, 24'h000018},
      '{2'd2, 2'd1, 24'h000006, 1'b1, 1'b0, 8'h03, 2'd0, 4'd1, 24'h000003},
      '{2'd3, 2'd0, 24'h000007, 1'b0, 1'b1, 8'h01, 2'd0, 4'd1, 24'h000007},
      '{2'd2, 2'd3, 24'h000020, 1'b1, 1'b0, 8'h0F, 2'd0, 4'd4, 24'h000010},
      '{2'd0, 2'd0, 24'h000005, 1'b1, 1'b0, 8'h01, 2'd0, 4'd1, 24'h000002},
      '{2'd2, 2'd2, 24'h000040, 1'b0, 1'b1, 8'h0F, 2'd1, 4'd2, 24'h000020}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              big_endian = 1'b0;
   logic [NUM_CS-1:0] cs_is_8bit = 4'b1010;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [1:0]        req_cs = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [1:0]        req_size = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [7:0]        req_be = '0;
   logic              ext_valid;
   logic              ext_ready = 1'b0;
   logic              ext_write;
   logic [NUM_CS-1:0] ext_cs;
   logic [ADDR_W-1:0] ext_addr;
   logic [15:0]       ext_wdata;
   logic [1:0]        ext_be;
   logic [15:0]       ext_rdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;

   int n_chk = 0;
   int n_bad = 0;
   int cur_dly = 0;
   int wcnt = 0;
   int nbeat = 0;
   int nrsp = 0;
   logic [63:0] rsp_word;
   logic        ready_at_rsp;
   logic [23:0] lg_addr [16];
   logic [15:0] lg_wd   [16];
   logic [1:0]  lg_be   [16];
   logic [3:0]  lg_cs   [16];

   always #2 clk = ~clk;

   bus_width_splitter #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .cs_is_8bit(cs_is_8bit),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .req_be(req_be),
      .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write), .ext_cs(ext_cs),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_be(ext_be), .ext_rdata(ext_rdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [15:0] rd_val(input logic [23:0] a);
      return {a[7:0] ^ 8'hC3, a[7:0] + 8'h11};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // external device model and response monitor, all on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (ext_ready) begin
            ext_ready = 1'b0;
            wcnt = 0;
         end else if (ext_valid) begin
            if (wcnt >= cur_dly) begin
               ext_ready = 1'b1;
               ext_rdata = rd_val(ext_addr);
               if (nbeat < 16) begin
                  lg_addr[nbeat] = ext_addr;
                  lg_wd[nbeat]   = ext_wdata;
                  lg_be[nbeat]   = ext_be;
                  lg_cs[nbeat]   = ext_cs;
               end
               nbeat++;
            end else begin
               wcnt++;
            end
         end
         if (rsp_valid) begin
            nrsp++;
            rsp_word = rsp_rdata;
            ready_at_rsp = req_ready;
         end
      end
   end

   task automatic run_vec(input vec_t v, input int idx);
      int devb, sizeb, n, lane;
      logic [63:0] wd, exp_rd, mask, bmask;
      wd = 64'h0123_4567_89AB_CDEF ^ {8{8'(idx * 17)}};
      @(negedge clk);
      big_endian = v.bige;
      cur_dly = int'(v.dly);
      nbeat = 0;
      nrsp = 0;
      req_cs = v.cs; req_size = v.size; req_addr = v.addr; req_write = v.wr;
      req_wdata = wd; req_be = v.be; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, $sformatf("R8 ready low after accept v%0d", idx), 64'(req_ready), 64'd0);
      for (int t = 0; t < 200 && nrsp == 0; t++) @(negedge clk);
      chk(ready_at_rsp == 1'b1, $sformatf("R8 ready back with completion v%0d", idx), 64'(ready_at_rsp), 64'd1);
      repeat (3) @(negedge clk);
      chk(nrsp == 1, $sformatf("R7 one completion v%0d", idx), 64'(nrsp), 64'd1);
      chk(nbeat == int'(v.nb), $sformatf("R1 R6 beat count v%0d", idx), 64'(nbeat), 64'(v.nb));
      devb  = cs_is_8bit[v.cs] ? 1 : 2;
      sizeb = 1 << v.size;
      n     = (sizeb > devb) ? sizeb / devb : 1;
      mask  = (devb == 1) ? 64'hFF : 64'hFFFF;
      bmask = (devb == 1) ? 64'h1 : 64'h3;
      exp_rd = '0;
      for (int k = 0; k < n && k < nbeat && k < 16; k++) begin
         lane = v.bige ? (n - 1 - k) : k;
         chk(lg_addr[k] == v.base + 24'(k), $sformatf("R3 R4 beat %0d addr v%0d", k, idx),
             64'(lg_addr[k]), 64'(v.base + 24'(k)));
         chk(lg_cs[k] == 4'(1 << v.cs), $sformatf("R2 beat %0d cs v%0d", k, idx),
             64'(lg_cs[k]), 64'(1 << v.cs));
         if (v.wr) begin
            chk(64'(lg_wd[k]) == ((wd >> (lane * devb * 8)) & mask),
                $sformatf("R5 R9 beat %0d data v%0d", k, idx), 64'(lg_wd[k]), (wd >> (lane * devb * 8)) & mask);
            chk(64'(lg_be[k]) == ((64'(v.be) >> (lane * devb)) & bmask),
                $sformatf("R6 beat %0d enables v%0d", k, idx), 64'(lg_be[k]), (64'(v.be) >> (lane * devb)) & bmask);
         end
         exp_rd = exp_rd | ((64'(rd_val(v.base + 24'(k))) & mask) << (lane * devb * 8));
      end
      if (!v.wr)
         chk(rsp_word == exp_rd, $sformatf("R7 R5 read word v%0d", idx), rsp_word, exp_rd);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && ext_valid == 1'b0, "R10 idle during reset",
          {62'd0, req_ready, ext_valid}, 64'h2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
      chk(ext_valid == 1'b0 && ext_cs == '0, "R10 no beat after reset", {59'd0, ext_valid, ext_cs}, 64'd0);
      chk(rsp_valid == 1'b0, "R10 no completion after reset", 64'(rsp_valid), 64'd0);
      for (int i = 0; i < 12; i++) run_vec(VECS[i], i);
      // directed: same 32-bit read in both orders gives identical addresses (R3)
      begin
         logic [23:0] a_le [2];
         run_vec('{2'd2, 2'd2, 24'h000100, 1'b0, 1'b0, 8'hFF, 2'd0, 4'd2, 24'h000080}, 12);
         a_le[0] = lg_addr[0]; a_le[1] = lg_addr[1];
         run_vec('{2'd2, 2'd2, 24'h000100, 1'b0, 1'b1, 8'hFF, 2'd0, 4'd2, 24'h000080}, 13);
         chk(lg_addr[0] == a_le[0] && lg_addr[1] == a_le[1], "R3 order independent of endianness",
             {16'd0, lg_addr[0], lg_addr[1]}, {16'd0, a_le[0], a_le[1]});
      end
      // directed: all-zero enables on a 64-bit write to an 8-bit device still gives 8 beats (R6)
      run_vec('{2'd1, 2'd3, 24'h000200, 1'b1, 1'b1, 8'h00, 2'd0, 4'd8, 24'h000200}, 14);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule